// File: doc/BRIEF.md
# RTD Converter Serial Register Block

This block is the digital register side of a resistance-to-digital temperature converter. It is an SPI slave using mode 1: the clock idles low, the slave samples MOSI on the falling edge of SCK, and it drives MISO after the rising edge. A host reaches eight byte-wide registers through it: a control byte, the two bytes of the latest conversion result, the two bytes of an upper limit, the two bytes of a lower limit, and a fault byte. The converter core stays outside this block. It delivers each 15-bit result with a one-cycle strobe. It reports the end of a fault-detection cycle with another strobe and four circuit-fault flags.

SCK, CS_n and MOSI are resynchronised into the system clock domain, so SCK must run several times slower than `clk`. A transfer starts when CS_n falls. The first byte is an address byte and every byte after it is data. Data bytes go to consecutive registers, so the host can read or write a two-byte value in one burst. The block compares each accepted conversion against both limits. A limit violation or a reported circuit fault sets sticky flags, and these flags are mirrored into the low bit of the result. The host clears them with a command bit.

Top module: `rtd_spi_regs`

## Requirements
- R1: While CS_n is low, the block shifts in one MOSI bit on each falling SCK edge and changes MISO only after rising SCK edges. The first byte of a transfer is the address: bit 7 = 1 selects write, bits 2:0 select the register index, and bits 6:3 are ignored. Raising CS_n in the middle of a byte discards that byte, and the next transfer starts again with an address byte.
- R2: Register indices are 0 control, 1 result high byte, 2 result low byte, 3/4 upper limit high/low, 5/6 lower limit high/low, and 7 fault. Only indices 0, 3, 4, 5 and 6 accept writes. A write to 1, 2 or 7 leaves the register unchanged.
- R3: Each data byte after the address moves the register index up by one, and the index wraps from 7 to 0.
- R4: After reset, control, result and fault read 0x00, both upper-limit bytes read 0xFF, both lower-limit bytes read 0x00, and MISO is low.
- R5: Control bit 1 is a clear command. Writing it as 1 zeroes the fault byte and result bit 0. The bit always reads back as 0.
- R6: Control bit 5 (single conversion) returns to 0 when the next conversion strobe is accepted.
- R7: A conversion strobe is accepted only when control bit 6 (continuous) or bit 5 is set. An accepted code is stored with the result high byte = code[14:7] and the result low byte = {code[6:0], flag}. A strobe that is not accepted changes nothing.
- R8: Each accepted code is compared against the upper limit bits 15:1 and the lower limit bits 15:1. A code strictly above the upper limit sets fault bit 7, and a code strictly below the lower limit sets fault bit 6. Fault bits stay set until cleared.
- R9: Writing 01 to control bits 3:2 requests a fault-detection cycle. When the completion strobe arrives and those bits are nonzero, they return to 00 and the four circuit flags are ORed into fault bits 5:2. A completion strobe that arrives while bits 3:2 are 00 is ignored.
- R10: Result bit 0 reads 1 exactly when some fault bit is set, and fault bits 1:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low transfer frame |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| conv_done | input | 1 | One-cycle strobe: a new conversion code is ready |
| conv_code | input | 15 | Conversion code, valid with conv_done |
| fdet_done | input | 1 | One-cycle strobe: the fault-detection cycle has finished |
| fdet_flags | input | 4 | Circuit and supply fault flags, valid with fdet_done |

## Verification
The hardest case to reach from the ports is a burst that runs off the top of the register map. To set it up, each conversion case first sends a clear command and then a strobe, and then a single read starts at the fault index. That read wraps through the control byte into both result bytes, so the flags, the self-clearing control bits and the stored code are all observed in one transfer. Directed sequences cover the rest: a single conversion followed by a second strobe that must be ignored, a detection-completion strobe that arrives with no request pending, and a frame cut off in the middle of a byte.

// File: rtl/rtd_spi_pkg.sv
`timescale 1ns/1ps
package rtd_spi_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 15;
    localparam int WORD_W = CODE_W + 1;
    localparam int IDX_W  = 3;
    localparam int FDET_W = 4;

    // control byte bit positions
    localparam int CB_BIAS    = 7;
    localparam int CB_AUTO    = 6;
    localparam int CB_ONESHOT = 5;
    localparam int CB_WIRE3   = 4;
    localparam int CB_FDET_HI = 3;
    localparam int CB_FDET_LO = 2;
    localparam int CB_CLR     = 1;
    localparam int CB_MAINS50 = 0;

    // fault byte bit positions
    localparam int FB_ABOVE  = 7;
    localparam int FB_BELOW  = 6;
    localparam int FB_DET_HI = 5;
    localparam int FB_DET_LO = FB_DET_HI - FDET_W + 1;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTRL   = 3'd0,
        IDX_RES_HI = 3'd1,
        IDX_RES_LO = 3'd2,
        IDX_UPR_HI = 3'd3,
        IDX_UPR_LO = 3'd4,
        IDX_LWR_HI = 3'd5,
        IDX_LWR_LO = 3'd6,
        IDX_FAULT  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [WORD_W-1:0] res;
        logic [WORD_W-1:0] upr;
        logic [WORD_W-1:0] lwr;
        logic [BYTE_W-1:0] flt;
    } regs_t;
endpackage

// File: rtl/rtd_limit_cmp.sv
`timescale 1ns/1ps
module rtd_limit_cmp
    import rtd_spi_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [WORD_W-1:0] upr,
    input  logic [WORD_W-1:0] lwr,
    output logic              above,
    output logic              below
);
    // limits are left-justified like the result: bit 0 carries no magnitude
    logic unused_lsbs;
    assign unused_lsbs = upr[0] ^ lwr[0];

    always_comb begin
        above = code > upr[WORD_W-1:1];
        below = code < lwr[WORD_W-1:1];
    end
endmodule

// File: rtl/rtd_spi_shifter.sv
`timescale 1ns/1ps
module rtd_spi_shifter #(
    parameter int BW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          cs_n,
    input  logic          mosi,
    input  logic [BW-1:0] tx_byte,
    output logic          miso,
    output logic          cs_act,
    output logic          rx_valid,
    output logic [BW-1:0] rx_byte
);
    localparam int CW = (BW > 1) ? $clog2(BW) : 1;

    typedef struct packed {
        logic          sck_prev;
        logic [CW-1:0] cnt;
        logic [BW-1:0] rx_sh;
        logic [BW-1:0] tx_sh;
        logic          vld;
        logic [BW-1:0] rxb;
    } sh_t;

    logic [SYNC_STAGES-1:0] sck_sync, cs_sync, mosi_sync;
    sh_t sh_d, sh_q;
    logic sck_s, mosi_s, rise, fall;
    logic unused_msb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sync  <= '0;
            cs_sync   <= '1;
            mosi_sync <= '0;
        end else begin
            sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck};
            cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
            mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
        end
    end

    assign sck_s      = sck_sync[SYNC_STAGES-1];
    assign mosi_s     = mosi_sync[SYNC_STAGES-1];
    assign cs_act     = !cs_sync[SYNC_STAGES-1];
    assign rise       = sck_s && !sh_q.sck_prev;
    assign fall       = !sck_s && sh_q.sck_prev;
    assign unused_msb = sh_q.rx_sh[BW-1];

    always_comb begin
        sh_d          = sh_q;
        sh_d.vld      = 1'b0;
        sh_d.sck_prev = sck_s;
        if (!cs_act) begin
            sh_d.cnt   = '0;
            sh_d.tx_sh = '0;
        end else begin
            if (rise) begin
                if (sh_q.cnt == '0) sh_d.tx_sh = tx_byte;
                else                sh_d.tx_sh = {sh_q.tx_sh[BW-2:0], 1'b0};
            end
            if (fall) begin
                sh_d.rx_sh = {sh_q.rx_sh[BW-2:0], mosi_s};
                if (sh_q.cnt == CW'(BW - 1)) begin
                    sh_d.cnt = '0;
                    sh_d.vld = 1'b1;
                    sh_d.rxb = {sh_q.rx_sh[BW-2:0], mosi_s};
                end else begin
                    sh_d.cnt = sh_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign miso     = sh_q.tx_sh[BW-1];
    assign rx_valid = sh_q.vld;
    assign rx_byte  = sh_q.rxb;
endmodule

// File: rtl/rtd_reg_bank.sv
`timescale 1ns/1ps
module rtd_reg_bank
    import rtd_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_code,
    input  logic              fdet_done,
    input  logic [FDET_W-1:0] fdet_flags,
    output regs_t             regs,
    output logic [IDX_W-1:0]  ptr
);
    typedef struct packed {
        regs_t            regs;
        logic [IDX_W-1:0] ptr;
        logic             addr_phase;
        logic             wr;
    } bank_t;

    localparam regs_t REGS_RST = '{ctrl: '0, res: '0, upr: '1, lwr: '0, flt: '0};
    localparam bank_t BANK_RST = '{regs: REGS_RST, ptr: '0, addr_phase: 1'b1, wr: 1'b0};

    bank_t bk_d, bk_q;
    logic [BYTE_W-1:0] flt_n;
    logic above, below, conv_ok, fdet_ok, clr;
    logic unused_addr_bits;

    assign unused_addr_bits = ^rx_byte[BYTE_W-2:IDX_W];

    rtd_limit_cmp u_cmp (
        .code  (conv_code),
        .upr   (bk_q.regs.upr),
        .lwr   (bk_q.regs.lwr),
        .above (above),
        .below (below)
    );

    always_comb begin
        bk_d    = bk_q;
        flt_n   = bk_q.regs.flt;
        clr     = 1'b0;
        conv_ok = conv_done && (bk_q.regs.ctrl[CB_AUTO] || bk_q.regs.ctrl[CB_ONESHOT]);
        fdet_ok = fdet_done && (bk_q.regs.ctrl[CB_FDET_HI:CB_FDET_LO] != 2'b00);

        if (conv_ok) begin
            bk_d.regs.res[WORD_W-1:1]    = conv_code;
            flt_n[FB_ABOVE]              = flt_n[FB_ABOVE] | above;
            flt_n[FB_BELOW]              = flt_n[FB_BELOW] | below;
            bk_d.regs.ctrl[CB_ONESHOT]   = 1'b0;
        end

        if (fdet_ok) begin
            bk_d.regs.ctrl[CB_FDET_HI:CB_FDET_LO] = 2'b00;
            flt_n[FB_DET_HI:FB_DET_LO] = flt_n[FB_DET_HI:FB_DET_LO] | fdet_flags;
        end

        if (!cs_act) begin
            bk_d.addr_phase = 1'b1;
        end else if (rx_valid) begin
            if (bk_q.addr_phase) begin
                bk_d.addr_phase = 1'b0;
                bk_d.wr         = rx_byte[BYTE_W-1];
                bk_d.ptr        = rx_byte[IDX_W-1:0];
            end else begin
                if (bk_q.wr) begin
                    case (bk_q.ptr)
                        IDX_CTRL: begin
                            bk_d.regs.ctrl         = rx_byte;
                            bk_d.regs.ctrl[CB_CLR] = 1'b0;
                            clr                    = rx_byte[CB_CLR];
                        end
                        IDX_UPR_HI: bk_d.regs.upr[WORD_W-1:BYTE_W] = rx_byte;
                        IDX_UPR_LO: bk_d.regs.upr[BYTE_W-1:0]      = rx_byte;
                        IDX_LWR_HI: bk_d.regs.lwr[WORD_W-1:BYTE_W] = rx_byte;
                        IDX_LWR_LO: bk_d.regs.lwr[BYTE_W-1:0]      = rx_byte;
                        default: ;
                    endcase
                end
                bk_d.ptr = bk_q.ptr + 1'b1;
            end
        end

        if (clr) flt_n = '0;
        bk_d.regs.flt    = flt_n;
        bk_d.regs.res[0] = |flt_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= BANK_RST;
        else        bk_q <= bk_d;
    end

    assign regs = bk_q.regs;
    assign ptr  = bk_q.ptr;
endmodule

// File: rtl/rtd_spi_regs.sv
`timescale 1ns/1ps
module rtd_spi_regs
    import rtd_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_code,
    input  logic              fdet_done,
    input  logic [FDET_W-1:0] fdet_flags
);
    logic              cs_act, rx_valid;
    logic [BYTE_W-1:0] rx_byte, rd_byte;
    regs_t             regs;
    logic [IDX_W-1:0]  ptr;

    rtd_spi_shifter #(.BW(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .tx_byte  (rd_byte),
        .miso     (miso),
        .cs_act   (cs_act),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    rtd_reg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .conv_done  (conv_done),
        .conv_code  (conv_code),
        .fdet_done  (fdet_done),
        .fdet_flags (fdet_flags),
        .regs       (regs),
        .ptr        (ptr)
    );

    always_comb begin
        case (ptr)
            IDX_CTRL:   rd_byte = regs.ctrl;
            IDX_RES_HI: rd_byte = regs.res[WORD_W-1:BYTE_W];
            IDX_RES_LO: rd_byte = regs.res[BYTE_W-1:0];
            IDX_UPR_HI: rd_byte = regs.upr[WORD_W-1:BYTE_W];
            IDX_UPR_LO: rd_byte = regs.upr[BYTE_W-1:0];
            IDX_LWR_HI: rd_byte = regs.lwr[WORD_W-1:BYTE_W];
            IDX_LWR_LO: rd_byte = regs.lwr[BYTE_W-1:0];
            default:    rd_byte = regs.flt;
        endcase
    end
endmodule

// File: rtl/rtd_spi_regs_chk.sv
`timescale 1ns/1ps
module rtd_spi_regs_chk
    import rtd_spi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [CODE_W-1:0] conv_code,
    input logic              fdet_done,
    input logic              rx_valid,
    input regs_t             regs
);
    logic unused_chk;
    assign unused_chk = ^{regs.res[0], regs.flt[FB_DET_HI:0], regs.ctrl[CB_BIAS],
                          regs.ctrl[CB_WIRE3], regs.ctrl[CB_CLR:0]};

    // R2: the result word moves only on a conversion strobe, never by a bus write
    assert_result_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(regs.res[WORD_W-1:1]));

    // R6: single-conversion bit drops once a strobe is taken
    assert_oneshot_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && regs.ctrl[CB_ONESHOT] && !rx_valid) |=> !regs.ctrl[CB_ONESHOT]);

    // R7: with both conversion modes off a strobe leaves the result alone
    assert_idle_strobe_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !regs.ctrl[CB_AUTO] && !regs.ctrl[CB_ONESHOT]) |=> $stable(regs.res[WORD_W-1:1]));

    // R8: code above the upper limit raises the high flag
    assert_above_limit_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && (regs.ctrl[CB_AUTO] || regs.ctrl[CB_ONESHOT]) && !rx_valid
         && (conv_code > regs.upr[WORD_W-1:1])) |=> regs.flt[FB_ABOVE]);

    // R8: code below the lower limit raises the low flag
    assert_below_limit_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && (regs.ctrl[CB_AUTO] || regs.ctrl[CB_ONESHOT]) && !rx_valid
         && (conv_code < regs.lwr[WORD_W-1:1])) |=> regs.flt[FB_BELOW]);

    // R9: a pending detection request returns to idle on completion
    assert_fdet_returns_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fdet_done && (regs.ctrl[CB_FDET_HI:CB_FDET_LO] != 2'b00) && !rx_valid)
        |=> (regs.ctrl[CB_FDET_HI:CB_FDET_LO] == 2'b00));
endmodule

bind rtd_spi_regs rtd_spi_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .conv_code (conv_code),
    .fdet_done (fdet_done),
    .rx_valid  (rx_valid),
    .regs      (regs)
);

// File: tb/rtd_spi_regs_test.sv
`timescale 1ns/1ps
module rtd_spi_regs_test;
    localparam int HALF = 4;

    typedef struct packed {
        logic [14:0] code;
        logic [7:0]  msb;
        logic [7:0]  lsb;
        logic [7:0]  flt;
    } vec_t;

    // limits used by the table: upper 0x8000 (0x4000), lower 0x2000 (0x1000)
    localparam vec_t VEC [0:6] = '{
        '{15'h2000, 8'h40, 8'h00, 8'h00},
        '{15'h4000, 8'h80, 8'h00, 8'h00},
        '{15'h4001, 8'h80, 8'h03, 8'h80},
        '{15'h1000, 8'h20, 8'h00, 8'h00},
        '{15'h0FFF, 8'h1F, 8'hFF, 8'h40},
        '{15'h7FFF, 8'hFF, 8'hFF, 8'h80},
        '{15'h0000, 8'h00, 8'h01, 8'h40}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic conv_done = 1'b0;
    logic [14:0] conv_code = '0;
    logic fdet_done = 1'b0;
    logic [3:0] fdet_flags = '0;

    int total = 0;
    int bad = 0;
    logic [7:0] tx_buf [0:8];
    logic [7:0] rx_buf [0:8];

    always #2.5 clk = ~clk;

    rtd_spi_regs uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck        (sck),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .miso       (miso),
        .conv_done  (conv_done),
        .conv_code  (conv_code),
        .fdet_done  (fdet_done),
        .fdet_flags (fdet_flags)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic spi_xfer(input int n);
        cs_n = 1'b0;
        wait_clks(HALF);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                sck  = 1'b1;
                mosi = tx_buf[b][i];
                wait_clks(HALF);
                sck = 1'b0;
                rx_buf[b][i] = miso;
                wait_clks(HALF);
            end
        end
        wait_clks(HALF);
        cs_n = 1'b1;
        wait_clks(HALF);
    endtask

    task automatic write1(input logic [7:0] a, input logic [7:0] v);
        tx_buf[0] = a | 8'h80;
        tx_buf[1] = v;
        spi_xfer(2);
    endtask

    task automatic read_n(input logic [7:0] a, input int n);
        tx_buf[0] = a;
        for (int k = 1; k <= n; k++) tx_buf[k] = 8'h00;
        spi_xfer(n + 1);
    endtask

    task automatic conv(input logic [14:0] c);
        @(negedge clk);
        conv_code = c;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        wait_clks(2);
    endtask

    task automatic fdet(input logic [3:0] f);
        @(negedge clk);
        fdet_flags = f;
        fdet_done  = 1'b1;
        @(negedge clk);
        fdet_done = 1'b0;
        wait_clks(2);
    endtask

    initial begin
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(3);

        // R4 reset values, R3 burst across all indices
        check("R4", "miso idle", {7'd0, miso}, 8'h00);
        read_n(8'h00, 8);
        check("R4", "ctrl", rx_buf[1], 8'h00);
        check("R4", "res hi", rx_buf[2], 8'h00);
        check("R4", "res lo", rx_buf[3], 8'h00);
        check("R4", "upr hi", rx_buf[4], 8'hFF);
        check("R3", "upr lo", rx_buf[5], 8'hFF);
        check("R4", "lwr hi", rx_buf[6], 8'h00);
        check("R4", "lwr lo", rx_buf[7], 8'h00);
        check("R4", "fault", rx_buf[8], 8'h00);

        // R2/R3 limit write burst
        tx_buf[0] = 8'h83; tx_buf[1] = 8'h80; tx_buf[2] = 8'h00;
        tx_buf[3] = 8'h20; tx_buf[4] = 8'h00;
        spi_xfer(5);
        read_n(8'h03, 4);
        check("R2", "upr hi", rx_buf[1], 8'h80);
        check("R3", "upr lo", rx_buf[2], 8'h00);
        check("R2", "lwr hi", rx_buf[3], 8'h20);
        check("R3", "lwr lo", rx_buf[4], 8'h00);

        // conversion table: R7 R8 R10, read wraps 7 -> 0 (R3)
        for (int v = 0; v < 7; v++) begin
            write1(8'h00, 8'h42);
            conv(VEC[v].code);
            read_n(8'h07, 4);
            check("R8", $sformatf("fault v%0d", v), rx_buf[1], VEC[v].flt);
            check("R3", $sformatf("ctrl wrap v%0d", v), rx_buf[2], 8'h40);
            check("R7", $sformatf("res hi v%0d", v), rx_buf[3], VEC[v].msb);
            check("R10", $sformatf("res lo v%0d", v), rx_buf[4], VEC[v].lsb);
        end

        // R2 read-only indices
        write1(8'h01, 8'hAA);
        write1(8'h02, 8'h55);
        write1(8'h07, 8'h00);
        read_n(8'h01, 2);
        check("R2", "res hi kept", rx_buf[1], 8'h00);
        check("R2", "res lo kept", rx_buf[2], 8'h01);
        read_n(8'h07, 1);
        check("R2", "fault kept", rx_buf[1], 8'h40);

        // R5 clear command
        write1(8'h00, 8'h42);
        read_n(8'h00, 1);
        check("R5", "clear bit reads 0", rx_buf[1], 8'h40);
        read_n(8'h07, 1);
        check("R5", "fault cleared", rx_buf[1], 8'h00);
        read_n(8'h02, 1);
        check("R5", "flag cleared", rx_buf[1], 8'h00);

        // R7 strobe ignored with both modes off
        write1(8'h00, 8'h00);
        conv(15'h1234);
        read_n(8'h01, 2);
        check("R7", "ignored hi", rx_buf[1], 8'h00);
        check("R7", "ignored lo", rx_buf[2], 8'h00);

        // R6 single conversion
        write1(8'h00, 8'h20);
        read_n(8'h00, 1);
        check("R6", "oneshot set", rx_buf[1], 8'h20);
        conv(15'h2000);
        read_n(8'h00, 3);
        check("R6", "oneshot cleared", rx_buf[1], 8'h00);
        check("R6", "oneshot res hi", rx_buf[2], 8'h40);
        check("R6", "oneshot res lo", rx_buf[3], 8'h00);
        conv(15'h3000);
        read_n(8'h01, 1);
        check("R7", "second strobe ignored", rx_buf[1], 8'h40);

        // R9 fault-detection cycle
        write1(8'h00, 8'h04);
        read_n(8'h00, 1);
        check("R9", "fdet requested", rx_buf[1], 8'h04);
        fdet(4'b1010);
        read_n(8'h07, 4);
        check("R9", "fdet flags", rx_buf[1], 8'h28);
        check("R9", "fdet idle", rx_buf[2], 8'h00);
        check("R10", "flag from fdet", rx_buf[4], 8'h01);
        fdet(4'b0101);
        read_n(8'h07, 1);
        check("R9", "stray completion ignored", rx_buf[1], 8'h28);

        // R1 aborted frame
        cs_n = 1'b0;
        wait_clks(HALF);
        for (int i = 0; i < 4; i++) begin
            sck = 1'b1; mosi = 1'b1;
            wait_clks(HALF);
            sck = 1'b0;
            wait_clks(HALF);
        end
        cs_n = 1'b1;
        wait_clks(2 * HALF);
        read_n(8'h07, 2);
        check("R1", "after abort fault", rx_buf[1], 8'h28);
        check("R1", "after abort ctrl", rx_buf[2], 8'h00);

        // R1 address bits 6:3 ignored
        read_n(8'h7B, 1);
        check("R1", "upper addr bits", rx_buf[1], 8'h80);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule